// File: doc/BRIEF.md
# Request-Handshake to Wishbone Single-Transfer Bridge

This bridge lets a simple local agent issue single register accesses on a Wishbone classic bus. The agent presents a command bit, a register address and a write byte, then raises a level `req_ready`. The bridge captures the request and opens exactly one bus cycle. It keeps that cycle open until the slave acknowledges, then closes it and raises `req_done`.

On a read, the byte the slave returns at the acknowledge is registered. It stays on `req_rdata` after the bus cycle has ended, until a later read completes. `req_done` stays high for as long as the agent keeps `req_ready` high. The agent drops `req_ready` once it sees `req_done` and leaves at least one clock before its next request. The bridge therefore cannot turn one long `req_ready` level into a second transfer.

Top module: `hs_wb_bridge`

## Requirements
- R1: With the default parameter, `req_cmd` = 1 requests a write, which drives `wb_we_o` high during the cycle. `req_cmd` = 0 requests a read, which keeps `wb_we_o` low.
- R2: When `req_ready` is sampled high while the bridge is idle, `wb_cyc_o` and `wb_stb_o` are both high from the following clock.
- R3: For the whole bus cycle, `wb_adr_o`, `wb_dat_o` and `wb_we_o` carry the address, data and command captured at acceptance. A change on the local inputs after acceptance has no effect on them.
- R4: Without `wb_ack_i`, the bus cycle remains open for any number of clocks.
- R5: In the clock after `wb_ack_i` is sampled high during a cycle, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are low and `req_done` is high.
- R6: When a read completes, `req_rdata` equals the `wb_dat_i` value sampled with the acknowledge, and it is valid while `req_done` is high.
- R7: `req_done` stays high while `req_ready` stays high. It falls in the clock after `req_ready` is sampled low.
- R8: Holding `req_ready` high after completion starts no further bus cycle, so each request yields exactly one rising edge of `wb_cyc_o`.
- R9: `req_rdata` keeps its value through write transfers and idle time until the next read completes.
- R10: A synchronous active-high `rst` returns the bridge to idle and abandons any open cycle. After it, `wb_cyc_o`, `wb_stb_o`, `wb_we_o` and `req_done` are low and `req_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cmd | input | 1 | Transfer kind (1 write, 0 read by default) |
| req_addr | input | 3 | Register address of the request |
| req_wdata | input | 8 | Write byte of the request |
| req_ready | input | 1 | Level request strobe |
| req_rdata | output | 8 | Held read byte |
| req_done | output | 1 | Completion flag |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 3 | Bus address |
| wb_dat_o | output | 8 | Bus write data |
| wb_dat_i | input | 8 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench varies slave latency from zero to several clocks and holds `req_ready` high for extra clocks after completion. A bridge that re-armed on the level would open a second cycle and break the count of cycle starts. It scrambles the local command, address and data while a cycle is open, which exposes a bridge that forwards its inputs live instead of captured values. Writes return junk on `wb_dat_i`, so a bridge that captures on any acknowledge corrupts the held read byte. A reset in the middle of a long-stalled cycle must close the bus at once.

// File: rtl/hswb_pkg.sv
package hswb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_DONE = 2'd2
   } hswb_state_e;
endpackage

// File: rtl/hswb_ctrl.sv
module hswb_ctrl
   import hswb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 8,
   parameter bit          WR_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ready,
   input  logic              cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack,
   output logic              cyc,
   output logic              we,
   output logic [ADDR_W-1:0] adr,
   output logic [DATA_W-1:0] dat,
   output logic              done,
   output logic              cap_en
);
   hswb_state_e       state_q;
   logic              we_q;
   logic [ADDR_W-1:0] adr_q;
   logic [DATA_W-1:0] dat_q;
   logic              is_write;

   assign is_write = (cmd == WR_LEVEL);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         adr_q   <= '0;
         dat_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (ready) begin
               state_q <= ST_BUS;
               we_q    <= is_write;
               adr_q   <= addr;
               dat_q   <= wdata;
            end
            ST_BUS:  if (ack) state_q <= ST_DONE;
            ST_DONE: if (!ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cyc    = (state_q == ST_BUS);
   assign we     = cyc & we_q;
   assign adr    = adr_q;
   assign dat    = dat_q;
   assign done   = (state_q == ST_DONE);
   assign cap_en = cyc & ack & ~we_q;

   // R5
   ack_closes_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc && ack) |=> (!cyc && !we && done));
   // R4
   stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc && !ack) |=> cyc);
   // R3
   fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc && !ack) |=> ($stable(adr) && $stable(dat) && $stable(we)));
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done && ready) |=> done);
   // R8
   no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !cyc);
endmodule

// File: rtl/hswb_rdcap.sv
module hswb_rdcap #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (cap_en) q <= din;
   end
endmodule

// File: rtl/hs_wb_bridge.sv
module hs_wb_bridge #(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned DATA_W   = 8,
   parameter bit          WR_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_ready,
   output logic [DATA_W-1:0] req_rdata,
   output logic              req_done,
   output logic              wb_cyc_o,
   output logic              wb_stb_o,
   output logic              wb_we_o,
   output logic [ADDR_W-1:0] wb_adr_o,
   output logic [DATA_W-1:0] wb_dat_o,
   input  logic [DATA_W-1:0] wb_dat_i,
   input  logic              wb_ack_i
);
   localparam int unsigned MAX_W = 64;

   generate
      if (ADDR_W < 1 || ADDR_W > MAX_W) begin : g_bad_addr
         $error("hs_wb_bridge: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > MAX_W) begin : g_bad_data
         $error("hs_wb_bridge: DATA_W out of range");
      end
   endgenerate

   logic cyc_w;
   logic cap_en;

   hswb_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .WR_LEVEL (WR_LEVEL)
   ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .ready  (req_ready),
      .cmd    (req_cmd),
      .addr   (req_addr),
      .wdata  (req_wdata),
      .ack    (wb_ack_i),
      .cyc    (cyc_w),
      .we     (wb_we_o),
      .adr    (wb_adr_o),
      .dat    (wb_dat_o),
      .done   (req_done),
      .cap_en (cap_en)
   );

   hswb_rdcap #(.DATA_W(DATA_W)) u_rdcap (
      .clk    (clk),
      .rst    (rst),
      .cap_en (cap_en),
      .din    (wb_dat_i),
      .q      (req_rdata)
   );

   assign wb_cyc_o = cyc_w;
   assign wb_stb_o = cyc_w;

   // R2
   start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(wb_cyc_o) |-> $past(req_ready));
   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wb_cyc_o && wb_ack_i && !wb_we_o) |=> $stable(req_rdata));
   // R6
   rdata_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_cyc_o && wb_ack_i && !wb_we_o) |=> (req_rdata == $past(wb_dat_i)));
endmodule

// File: tb/hs_wb_bridge_test.sv
module hs_wb_bridge_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_cmd = 1'b0;
   logic [2:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_ready = 1'b0;
   logic [7:0] req_rdata;
   logic       req_done;
   logic       wb_cyc_o, wb_stb_o, wb_we_o;
   logic [2:0] wb_adr_o;
   logic [7:0] wb_dat_o;
   logic [7:0] wb_dat_i = '0;
   logic       wb_ack_i = 1'b0;

   int checks = 0;
   int fails  = 0;
   int lat    = 0;
   int cnt    = 0;
   int nreq   = 0;
   int rises  = 0;
   bit prev_cyc = 1'b0;
   bit started  = 1'b0;
   bit finished = 1'b0;
   logic [7:0] mem [8];

   // reference model state
   int         m_mode = 0;  // 0 idle, 1 on bus, 2 reporting
   bit         m_wr   = 1'b0;
   logic [2:0] m_adr  = '0;
   logic [7:0] m_dat  = '0;
   logic [7:0] m_rd   = '0;

   always #4 clk = ~clk;

   hs_wb_bridge uut (
      .clk(clk), .rst(rst), .req_cmd(req_cmd), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
      .req_done(req_done), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
      .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
      .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         m_mode <= 0; m_wr <= 0; m_adr <= '0; m_dat <= '0; m_rd <= '0;
      end else if (m_mode == 0) begin
         if (req_ready) begin
            m_mode <= 1; m_wr <= (req_cmd == 1'b1); m_adr <= req_addr; m_dat <= req_wdata;
         end
      end else if (m_mode == 1) begin
         if (wb_ack_i) begin
            m_mode <= 2;
            if (!m_wr) m_rd <= wb_dat_i;
         end
      end else if (!req_ready) begin
         m_mode <= 0;
      end
   end

   // compare every clock, away from the rising edge
   always @(negedge clk) begin
      if (started && !finished) begin
         check("R2 cyc", wb_cyc_o, m_mode == 1);
         check("R2 stb", wb_stb_o, m_mode == 1);
         check("R1 we", wb_we_o, (m_mode == 1) && m_wr);
         check("R3 adr", wb_adr_o, m_adr);
         check("R3 dat_o", wb_dat_o, m_dat);
         check("R7 done", req_done, m_mode == 2);
         check("R9 rdata", req_rdata, m_rd);
         if (wb_cyc_o && !prev_cyc) rises++;
         prev_cyc = wb_cyc_o;
      end
   end

   // slave with programmable acknowledge latency
   always @(negedge clk) begin
      if (wb_cyc_o && !wb_ack_i) begin
         if (cnt >= lat) begin
            wb_ack_i = 1'b1;
            if (wb_we_o) begin
               mem[wb_adr_o] = wb_dat_o;
               wb_dat_i = ~wb_dat_o;
            end else begin
               wb_dat_i = mem[wb_adr_o];
            end
            cnt = 0;
         end else begin
            cnt++;
         end
      end else begin
         wb_ack_i = 1'b0;
         if (!wb_cyc_o) cnt = 0;
      end
   end

   task automatic do_req(input bit c, input logic [2:0] a, input logic [7:0] d,
                         input int l, input int hold, input bit scramble);
      @(negedge clk);
      lat = l; req_cmd = c; req_addr = a; req_wdata = d; req_ready = 1'b1;
      nreq++;
      if (scramble) begin
         @(negedge clk);
         req_cmd = ~c; req_addr = ~a; req_wdata = ~d;
      end
      do @(negedge clk); while (!req_done);
      repeat (hold) @(negedge clk);
      check("R7 done held", req_done, 1);
      req_ready = 1'b0;
      @(negedge clk);
      check("R7 done falls", req_done, 0);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) mem[i] = 8'(i * 17);
      repeat (3) @(negedge clk);
      check("R10 reset cyc", wb_cyc_o, 0);
      check("R10 reset done", req_done, 0);
      check("R10 reset rdata", req_rdata, 0);
      rst = 1'b0;

      do_req(1'b1, 3'd3, 8'hA5, 0, 0, 0);
      do_req(1'b1, 3'd5, 8'h3C, 3, 4, 0);
      do_req(1'b0, 3'd3, 8'h00, 2, 0, 0);
      check("R6 read byte", req_rdata, 8'hA5);
      do_req(1'b1, 3'd6, 8'h77, 4, 1, 1);
      check("R3 scrambled write landed", mem[6], 8'h77);
      check("R9 rdata after write", req_rdata, 8'hA5);
      do_req(1'b0, 3'd5, 8'hFF, 7, 2, 1);
      check("R6 read after stall", req_rdata, 8'h3C);
      for (int i = 0; i < 8; i++) do_req(1'b1, 3'(i), 8'(8'hC0 + i), i % 3, i % 2, 0);
      for (int i = 0; i < 8; i++) begin
         do_req(1'b0, 3'(7 - i), 8'h00, i % 4, 0, 0);
         check("R6 sweep read", req_rdata, 8'(8'hC7 - i));
      end

      // reset during a stalled cycle
      @(negedge clk);
      lat = 1000; req_cmd = 1'b1; req_addr = 3'd1; req_wdata = 8'h11; req_ready = 1'b1;
      nreq++;
      repeat (5) @(negedge clk);
      check("R4 still open", wb_cyc_o, 1);
      rst = 1'b1;
      @(negedge clk);
      check("R10 abort cyc", wb_cyc_o, 0);
      check("R10 abort we", wb_we_o, 0);
      check("R10 abort done", req_done, 0);
      check("R10 abort rdata", req_rdata, 0);
      req_ready = 1'b0;
      rst = 1'b0;
      lat = 0;
      repeat (3) @(negedge clk);
      check("R8 one cycle per request", rises, nreq);
      finish_run();
   end
endmodule